// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a small 32-bit processor core that completes every instruction in one clock: fetch from an internal instruction store, decode, register read, ALU operation, data access and register write-back all happen between two rising edges. It implements a compact load/store subset: register-register add, subtract, and, or and set-less-than, word load, word store, branch-if-equal and an absolute jump. A register file of 32 words, one shared ALU, a combinational main decoder, a reduced ALU-control decoder and three selectors make up the datapath. These selectors choose the destination register, the second ALU operand and the write-back source.

Both memories are internal arrays. Each one is written on the clock edge and read combinationally, so a load returns its word in the same cycle as the address is formed. While reset is held, a loader port fills both memories. After reset is released, the core runs from address 0. Two observation ports read any register and any data word combinationally, so the state can be inspected after a run.

Top module: `scc_core`

## Requirements
- R1: Reset is synchronous and active high; a clock edge with `rst` high sets the PC to 0. The loader (`ld_imem_we`, `ld_dmem_we` with `ld_addr`, `ld_data`) writes the memories only on edges with `rst` high, and is ignored otherwise. The core writes no register and no data word while `rst` is high.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] and target [25:0]. Opcode 000000 with funct 100000 writes reg[rd] = reg[rs] + reg[rt], and with funct 100010 writes reg[rd] = reg[rs] - reg[rt] (modulo 2^32).
- R3: Opcode 000000 with funct 100100 writes the bitwise AND, with 100101 the bitwise OR, and with 101010 writes 1 if reg[rs] < reg[rt] as signed values, else 0.
- R4: Opcode 100011 (load) writes reg[rt] = dmem[reg[rs] + sext(imm)], with the word index taken from address bits [DAW+1:2]. The loaded value is available in the same cycle.
- R5: Opcode 101011 (store) writes dmem at the same index with reg[rt] and leaves the register file unchanged.
- R6: Opcode 000100 (branch-if-equal) sets the next PC to PC+4+(sext(imm)<<2) when reg[rs] equals reg[rt], and to PC+4 otherwise. Negative offsets branch backwards.
- R7: Opcode 000010 (jump) sets the next PC to {PC+4 [31:28], target, 2'b00}.
- R8: All other instructions advance the PC by 4.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: An unlisted opcode writes neither the register file nor the data memory, and the PC advances by 4.
- R11: `dbg_reg_val` shows reg[`dbg_reg_sel`] and `dbg_mem_val` shows dmem[`dbg_mem_sel`], both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loader window |
| ld_imem_we | input | 1 | Loader write strobe for the instruction store |
| ld_dmem_we | input | 1 | Loader write strobe for the data store |
| ld_addr | input | IAW | Loader word index (data store uses the low DAW bits) |
| ld_data | input | 32 | Loader write word |
| pc_o | output | 32 | Current program counter |
| dbg_reg_sel | input | 5 | Register observation index |
| dbg_reg_val | output | 32 | Register observation value |
| dbg_mem_sel | input | DAW | Data word observation index |
| dbg_mem_val | output | 32 | Data word observation value |

## Verification
The bench targets the points where a single-cycle core goes wrong. A load feeds a dependent add in the next instruction, so a data path that returned load data a cycle late would leave a stale sum. A backward branch checks the sign extension of the offset, because a zero-extending design would jump far forward instead of escaping the small loop. Writes to register 0, an undefined opcode and stores are each checked for side effects on registers, since a decoder that leaked a write enable would corrupt state. The loader is also driven outside reset, and the ALU-control reduction is tested across all five function codes, so a misplaced term would turn subtract or set-less-than into the wrong operation. The PC is compared against a reference model every cycle, so a wrong redirect is caught on the cycle where it happens.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [3:0] ALUC_AND = 4'b0000;
    localparam logic [3:0] ALUC_OR  = 4'b0001;
    localparam logic [3:0] ALUC_ADD = 4'b0010;
    localparam logic [3:0] ALUC_SUB = 4'b0110;
    localparam logic [3:0] ALUC_SLT = 4'b0111;

    localparam logic [1:0] AOP_ADD   = 2'b00;
    localparam logic [1:0] AOP_SUB   = 2'b01;
    localparam logic [1:0] AOP_FUNCT = 2'b10;

    typedef struct packed {
        logic       dst_is_rd;
        logic       b_is_imm;
        logic       wb_from_mem;
        logic       reg_wr;
        logic       mem_rd;
        logic       mem_wr;
        logic       branch;
        logic [1:0] alu_op;
        logic       jump;
    } ctrl_t;

endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
    import scc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_wr    = 1'b1;
                ctrl.alu_op    = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.mem_rd      = 1'b1;
                ctrl.alu_op      = AOP_ADD;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
                ctrl.alu_op   = AOP_ADD;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/scc_aluctl.sv
module scc_aluctl (
    input  logic [1:0] alu_op,
    input  logic [3:0] funct,
    output logic [3:0] alu_ctl
);

    // alu_op 2'b11 is never produced by the main decoder; the
    // equations below treat it as a free term.
    always_comb begin
        alu_ctl[3] = 1'b0;
        alu_ctl[2] = alu_op[0] | (alu_op[1] & funct[1]);
        alu_ctl[1] = ~alu_op[1] | ~funct[2];
        alu_ctl[0] = alu_op[1] & (funct[0] | funct[3]);
    end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   ctl,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (ctl)
            ALUC_AND: y = a & b;
            ALUC_OR:  y = a | b;
            ALUC_ADD: y = a + b;
            ALUC_SUB: y = a - b;
            ALUC_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default:  y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int W       = 32,
    parameter int NREGS   = 32,
    localparam int RAW    = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [W-1:0]   wd,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    input  logic [RAW-1:0] ra3,
    output logic [W-1:0]   rd1,
    output logic [W-1:0]   rd2,
    output logic [W-1:0]   rd3
);

    logic [W-1:0] regs_d [NREGS];
    logic [W-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
        rd3 = (ra3 == '0) ? '0 : regs_q[ra3];
    end

endmodule

// File: rtl/scc_core.sv
module scc_core
    import scc_pkg::*;
#(
    parameter int  IMEM_WORDS = 256,
    parameter int  DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [IAW-1:0]    ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc_o,
    input  logic [4:0]        dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_val,
    input  logic [DAW-1:0]    dbg_mem_sel,
    output logic [XLEN-1:0]   dbg_mem_val
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_d [DMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    // Fetch and field split
    logic [XLEN-1:0] instr;
    logic [5:0]      opcode;
    logic [4:0]      rs, rt, rd;
    logic [5:0]      funct;
    logic [15:0]     imm16;
    logic [25:0]     target;

    assign instr  = imem_q[state_q.pc[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign funct  = instr[5:0];
    assign imm16  = instr[15:0];
    assign target = instr[25:0];

    // Decode
    ctrl_t      ctrl;
    logic [3:0] alu_ctl;

    scc_ctrl u_ctrl (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    scc_aluctl u_aluctl (
        .alu_op  (ctrl.alu_op),
        .funct   (funct[3:0]),
        .alu_ctl (alu_ctl)
    );

    // Register file
    logic            rf_we;
    logic [4:0]      rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic [XLEN-1:0] rf_rd1, rf_rd2;

    assign rf_we = ctrl.reg_wr & ~rst;
    assign rf_wa = ctrl.dst_is_rd ? rd : rt;

    scc_regfile #(
        .W     (XLEN),
        .NREGS (32)
    ) u_rf (
        .clk (clk),
        .we  (rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd),
        .ra1 (rs),
        .ra2 (rt),
        .ra3 (dbg_reg_sel),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .rd3 (dbg_reg_val)
    );

    // Execute
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;

    assign imm_sext = {{(XLEN-16){imm16[15]}}, imm16};
    assign alu_b    = ctrl.b_is_imm ? imm_sext : rf_rd2;

    scc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (rf_rd1),
        .b    (alu_b),
        .ctl  (alu_ctl),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data access and write-back
    logic [DAW-1:0]  dmem_idx;
    logic [XLEN-1:0] dmem_rdata;

    assign dmem_idx   = alu_y[DAW+1:2];
    assign dmem_rdata = dmem_q[dmem_idx];
    assign rf_wd      = ctrl.wb_from_mem ? dmem_rdata : alu_y;

    // Next PC
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_branch;
    logic [XLEN-1:0] pc_jump;
    logic            take_branch;

    assign pc_plus4    = state_q.pc + 32'd4;
    assign pc_branch   = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign pc_jump     = {pc_plus4[31:28], target, 2'b00};
    assign take_branch = ctrl.branch & alu_zero;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = '0;
        end else if (ctrl.jump) begin
            state_d.pc = pc_jump;
        end else if (take_branch) begin
            state_d.pc = pc_branch;
        end else begin
            state_d.pc = pc_plus4;
        end
    end

    always_comb begin
        imem_d = imem_q;
        if (rst && ld_imem_we) begin
            imem_d[ld_addr] = ld_data;
        end
    end

    always_comb begin
        dmem_d = dmem_q;
        if (rst) begin
            if (ld_dmem_we) begin
                dmem_d[ld_addr[DAW-1:0]] = ld_data;
            end
        end else if (ctrl.mem_wr) begin
            dmem_d[dmem_idx] = rf_rd2;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        imem_q  <= imem_d;
        dmem_q  <= dmem_d;
    end

    assign pc_o        = state_q.pc;
    assign dbg_mem_val = dmem_q[dbg_mem_sel];

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], funct[5:4], ctrl.mem_rd};

endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rf_rd1,
    input logic [31:0] rf_rd2,
    input logic        rf_we,
    input logic [4:0]  dbg_reg_sel,
    input logic [31:0] dbg_reg_val
);

    logic [5:0]  c_op;
    logic [31:0] c_seq;
    logic [31:0] c_btgt;
    logic [31:0] c_jtgt;
    logic        c_eq;

    assign c_op   = instr[31:26];
    assign c_seq  = pc_o + 32'd4;
    assign c_btgt = c_seq + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign c_jtgt = {c_seq[31:28], instr[25:0], 2'b00};
    assign c_eq   = (rf_rd1 == rf_rd2);

    AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc_o == 32'd0)); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        ((c_op != 6'b000100 || !c_eq) && c_op != 6'b000010) |=> (pc_o == $past(c_seq))); // R8

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (c_op == 6'b000100 && c_eq) |=> (pc_o == $past(c_btgt))); // R6

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
        (c_op == 6'b000010) |=> (pc_o == $past(c_jtgt))); // R7

    AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
        (c_op == 6'b101011) |-> !rf_we); // R5

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == 5'd0) |-> (dbg_reg_val == 32'd0)); // R9

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00); // R7

endmodule

bind scc_core scc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .instr       (instr),
    .rf_rd1      (rf_rd1),
    .rf_rd2      (rf_rd2),
    .rf_we       (rf_we),
    .dbg_reg_sel (dbg_reg_sel),
    .dbg_reg_val (dbg_reg_val)
);

// File: tb/scc_core_tb.sv
`timescale 1ns/1ps
module scc_core_tb;

    localparam int IW = 256;
    localparam int DW = 64;

    localparam logic [5:0] T_R  = 6'b000000;
    localparam logic [5:0] T_LW = 6'b100011;
    localparam logic [5:0] T_SW = 6'b101011;
    localparam logic [5:0] T_BQ = 6'b000100;
    localparam logic [5:0] T_J  = 6'b000010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [5:0]  dbg_mem_sel = '0;
    logic [31:0] dbg_mem_val;

    always #2.5 clk = ~clk;

    scc_core u_dut (
        .clk         (clk),
        .rst         (rst),
        .ld_imem_we  (ld_imem_we),
        .ld_dmem_we  (ld_dmem_we),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .pc_o        (pc_o),
        .dbg_reg_sel (dbg_reg_sel),
        .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel),
        .dbg_mem_val (dbg_mem_val)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] prog  [IW];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [DW];
    logic [31:0] m_pc;
    int          wp = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_r(input int s, input int t, input int d, input logic [5:0] f);
        return {T_R, 5'(s), 5'(t), 5'(d), 5'd0, f};
    endfunction

    function automatic logic [31:0] e_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    function automatic logic [31:0] e_j(input int w);
        return {T_J, 26'(w)};
    endfunction

    task automatic emit(input logic [31:0] ins);
        prog[wp] = ins;
        wp++;
    endtask

    // Reference model: one instruction per call; returns the tag of the PC rule.
    task automatic m_step(output string tag);
        logic [31:0] ins, p4, nx, sx, ad, a, b, res;
        logic [5:0]  op, fn;
        int s, t, d;
        ins = prog[m_pc[9:2]];
        op = ins[31:26]; s = int'(ins[25:21]); t = int'(ins[20:16]);
        d = int'(ins[15:11]); fn = ins[5:0];
        sx = {{16{ins[15]}}, ins[15:0]};
        p4 = m_pc + 32'd4; nx = p4; tag = "R8";
        a = m_reg[s]; b = m_reg[t]; ad = a + sx;
        case (op)
            T_R: begin
                case (fn)
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    default:   res = {31'd0, $signed(a) < $signed(b)};
                endcase
                if (d != 0) m_reg[d] = res;
            end
            T_LW: if (t != 0) m_reg[t] = m_mem[ad[7:2]];
            T_SW: m_mem[ad[7:2]] = b;
            T_BQ: begin
                tag = "R6";
                if (a == b) nx = p4 + {sx[29:0], 2'b00};
            end
            T_J: begin
                tag = "R7";
                nx = {p4[31:28], ins[25:0], 2'b00};
            end
            default: tag = "R10";
        endcase
        m_reg[0] = '0;
        m_pc = nx;
    endtask

    task automatic build_prog();
        logic [5:0] fl [5];
        int halt;
        fl[0] = 6'b100000; fl[1] = 6'b100010; fl[2] = 6'b100100;
        fl[3] = 6'b100101; fl[4] = 6'b101010;
        for (int k = 1; k < 32; k++) emit(e_i(T_LW, 0, k, 16'(k * 4)));
        emit(e_r(1, 2, 0, 6'b100000));            // R9 write to r0
        emit(e_i(T_SW, 0, 5, 16'd8));              // R5
        emit(e_i(T_LW, 0, 6, 16'd8));              // R4
        emit(e_r(6, 1, 7, 6'b100000));             // R4 same-cycle use
        emit(e_r(1, 1, 8, 6'b100010));             // R2 -> 0
        emit(e_i(T_BQ, 8, 0, 16'd1));              // R6 taken
        emit(e_r(1, 1, 9, 6'b100000));             // skipped
        emit(e_i(T_BQ, 1, 3, 16'd1));              // R6 likely not taken
        emit(e_r(1, 3, 10, 6'b101010));            // R3 slt
        emit(e_j(wp + 2));                         // R7
        emit(e_r(1, 1, 11, 6'b100000));            // skipped
        emit(e_i(6'b111111, 1, 2, 16'h0004));      // R10
        emit(e_r(3, 4, 12, 6'b100100));            // R3 and
        emit(e_r(3, 4, 13, 6'b100101));            // R3 or
        // backward branch: A: j A+2, A+1: j A+3, A+2: beq r0,r0,-2
        emit(e_j(wp + 2));
        emit(e_j(wp + 2));
        emit(e_i(T_BQ, 0, 0, 16'hFFFE));           // R6 negative offset
        for (int n = 0; n < 120; n++) begin
            int sel, s, t, d;
            sel = int'($urandom % 10);
            s = int'($urandom % 32); t = int'($urandom % 32); d = int'($urandom % 32);
            if (sel < 5)      emit(e_r(s, t, d, fl[$urandom % 5]));
            else if (sel < 7) emit(e_i(T_LW, 0, t, 16'(($urandom % DW) * 4)));
            else if (sel < 9) emit(e_i(T_SW, 0, t, 16'(($urandom % DW) * 4)));
            else emit(e_i(T_BQ, s, (($urandom % 2) == 0) ? s : t, 16'(1 + $urandom % 3)));
        end
        halt = wp;
        while (wp < IW) emit(e_j(halt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", pc_o, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        void'($urandom(32'd20240611));
        build_prog();
        for (int k = 0; k < DW; k++) m_mem[k] = $urandom;
        for (int k = 0; k < 32; k++) m_reg[k] = '0;

        @(negedge clk);
        for (int i = 0; i < IW; i++) begin
            ld_imem_we = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_imem_we = 1'b0;
        for (int i = 0; i < DW; i++) begin
            ld_dmem_we = 1'b1; ld_addr = 8'(i); ld_data = m_mem[i];
            @(negedge clk);
        end
        ld_dmem_we = 1'b0;

        chk("R1 reset pc", pc_o, 32'd0);
        dbg_mem_sel = 6'd17; #1;
        chk("R11 loaded word", dbg_mem_val, m_mem[17]);
        dbg_reg_sel = 5'd0; #1;
        chk("R9 r0 reads zero", dbg_reg_val, 32'd0);

        rst = 1'b0;
        m_pc = '0;
        for (int c = 0; c < 600; c++) begin
            chk("R8 pc lockstep", pc_o, m_pc);
            m_step(tag);
            @(negedge clk);
            if (pc_o !== m_pc) begin
                checks++; errors++;
                $display("FAIL %s pc actual=%h expected=%h", tag, pc_o, m_pc);
            end
        end

        for (int k = 0; k < 32; k++) begin
            dbg_reg_sel = 5'(k); #1;
            chk("R2/R3/R4/R9/R10 register", dbg_reg_val, m_reg[k]);
        end
        for (int k = 0; k < DW; k++) begin
            dbg_mem_sel = 6'(k); #1;
            chk("R5/R11 data word", dbg_mem_val, m_mem[k]);
        end

        // R1: loader ignored outside reset
        @(negedge clk);
        ld_dmem_we = 1'b1; ld_addr = 8'd3; ld_data = ~m_mem[3];
        @(negedge clk);
        ld_dmem_we = 1'b0;
        dbg_mem_sel = 6'd3; #1;
        chk("R1 loader outside reset", dbg_mem_val, m_mem[3]);

        // R1: reset in mid-run returns PC to zero
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again", pc_o, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule